// File: doc/BRIEF.md
# Microphone ADC Sampling Sequencer

This block paces a microphone capture path from the peripheral clock. Software programs four settings through a small write port: a sequence word that holds a unit-reset bit and a microphone-enable bit, a converter-enable bit, the length of one sample period in clock cycles, and a settling delay for the converter's reference voltage. Capture starts only when the converter enable and the microphone enable are both set and the reset bit is clear. After that, the block waits out the settling delay and then issues one conversion request per sample period.

The converter is outside the block. Its 10-bit result arrives on a parallel input and is latched at the clock edge that ends the request cycle. One cycle later the block presents it as a 16-bit word with a valid strobe.

Three sticky status flags report capture start, capture stop and the reset-held idle state. Software clears each flag by writing a one to its bit. Typical use:

1. Program the period and the settling delay.
2. Set the converter enable.
3. Set the microphone enable.
4. Collect one word per period.
5. Clear the enables to stop.

Top module: `mic_seq_top`

## Requirements
- R1: After the reset input is released, convReq, sampleValid and all three irqFlags bits are 0.
- R2: No conversion request is issued unless the converter enable (address 1, bit 0) and the microphone enable (address 0, bit 1) are both 1 and the unit-reset bit (address 0, bit 0) is 0. Either enable alone starts nothing.
- R3: With settling delay D (address 3), the first convReq cycle comes D+2 clock edges after the write edge that completes the enable condition.
- R4: While capture runs with period N (address 2, N≥1), successive convReq cycles are exactly N cycles apart.
- R5: A period value written while capture runs leaves the interval in progress unchanged. The new value applies from the next period boundary onward.
- R6: sampleValid is high exactly in the cycle after each convReq cycle. sampleWord then holds, in bits 9:0, the converter input value present during the convReq cycle, and bits 15:10 are zero.
- R7: Clearing either enable during the settling delay aborts it without a request. Enabling again restarts the full D+2 delay.
- R8: irqFlags bit 1 (capture started) is set no later than the cycle of the first conversion request of a run.
- R9: Clearing an enable while capture runs sets irqFlags bit 0 (capture stopped). No sampleValid follows that flag until capture is enabled again.
- R10: A write to address 4 clears each irqFlags bit whose data bit is 1 and leaves the bits written as 0 unchanged.
- R11: While the unit-reset bit is 1, capture is stopped, irqFlags bits 1:0 are 0 and bit 2 (idle under reset) is 1. Writing 0 to address 0 leaves the unit idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address (0 sequence, 1 converter enable, 2 period, 3 settling delay, 4 flag clear) |
| wrData | input | 16 | Register write data |
| adcData | input | 10 | Converter result |
| convReq | output | 1 | Conversion request, one cycle per sample |
| sampleValid | output | 1 | Sample word valid strobe |
| sampleWord | output | 16 | Right-aligned sample, upper bits zero |
| irqFlags | output | 3 | Sticky flags: bit 0 stopped, bit 1 started, bit 2 idle under reset |

## Verification
The sequencer state is visible at the ports mainly through the timing of convReq. A wrong settling count or a wrong period reload moves the first request, or the spacing between requests, by at least one cycle. The bench measures this on the very next request.

A corrupted sample path shows in the sampleValid cycle that follows the affected request. There the word is compared against the converter input recorded one cycle earlier.

A flag that is set or cleared wrongly shows on irqFlags one cycle after the strobe or write that should have moved it.

// File: rtl/mic_seq_pkg.sv
package mic_seq_pkg;

  // Register addresses on the write port
  localparam logic [2:0] ADDR_SEQ    = 3'd0;
  localparam logic [2:0] ADDR_ADC    = 3'd1;
  localparam logic [2:0] ADDR_PERIOD = 3'd2;
  localparam logic [2:0] ADDR_DELAY  = 3'd3;
  localparam logic [2:0] ADDR_FLAGS  = 3'd4;

  // Flag bit positions
  localparam int FLAG_STOP  = 0;
  localparam int FLAG_START = 1;
  localparam int FLAG_RSTID = 2;
  localparam int FLAG_N     = 3;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SETTLE = 2'd1,
    SEQ_RUN    = 2'd2
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic convIssue;
    logic firstConv;
    logic stopDone;
    logic rstHold;
  } seqStb_t;

endpackage

// File: rtl/mic_seq_ctrl.sv
module mic_seq_ctrl
  import mic_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 3,
  parameter int PERIOD_RST = 32768,
  parameter int DELAY_RST  = 164
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output seqStb_t           stb
);

  localparam int CMP_W = CNT_W + 1;

  logic             rstBit, micEn, adcEn;
  logic [CNT_W-1:0] periodReg, delayReg;
  logic [CNT_W-1:0] dlyCnt, perCnt, curEnd;
  seqState_e        state;
  logic             go;
  logic             periodEnd;

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rstBit    <= 1'b0;
      micEn     <= 1'b0;
      adcEn     <= 1'b0;
      periodReg <= CNT_W'(PERIOD_RST);
      delayReg  <= CNT_W'(DELAY_RST);
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_W'(ADDR_SEQ): begin
          rstBit <= wrData[0];
          micEn  <= wrData[1];
        end
        ADDR_W'(ADDR_ADC):    adcEn     <= wrData[0];
        ADDR_W'(ADDR_PERIOD): periodReg <= wrData[CNT_W-1:0];
        ADDR_W'(ADDR_DELAY):  delayReg  <= wrData[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign go        = adcEn && micEn && !rstBit;
  assign periodEnd = ({1'b0, perCnt} + CMP_W'(1)) >= {1'b0, curEnd};

  always_comb begin
    stb.rstHold   = rstBit;
    stb.convIssue = (state == SEQ_RUN) && go && (perCnt == '0);
    stb.firstConv = (state == SEQ_SETTLE) && go && (dlyCnt == delayReg);
    stb.stopDone  = (state == SEQ_RUN) && !go;
  end

  // Sequencer: idle -> settling delay -> periodic requests
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      dlyCnt <= '0;
      perCnt <= '0;
      curEnd <= '0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (go) begin
            state  <= SEQ_SETTLE;
            dlyCnt <= '0;
          end
        end
        SEQ_SETTLE: begin
          if (!go) begin
            state <= SEQ_IDLE;
          end else if (dlyCnt == delayReg) begin
            state  <= SEQ_RUN;
            perCnt <= '0;
            curEnd <= periodReg;
          end else begin
            dlyCnt <= dlyCnt + CNT_W'(1);
          end
        end
        SEQ_RUN: begin
          if (!go) begin
            state <= SEQ_IDLE;
          end else if (periodEnd) begin
            perCnt <= '0;
            curEnd <= periodReg;
          end else begin
            perCnt <= perCnt + CNT_W'(1);
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mic_seq_dp.sv
module mic_seq_dp
  import mic_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SMP_W  = 10,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStb_t           stb,
  input  logic [SMP_W-1:0]  adcData,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleWord,
  output logic [FLAG_N-1:0] irqFlags
);

  localparam int PAD_W = DATA_W - SMP_W;

  logic [FLAG_N-1:0] setVec, clrVec;
  logic              clrWrite;

  // Sample capture
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sampleValid <= 1'b0;
      sampleWord  <= '0;
    end else begin
      sampleValid <= stb.convIssue;
      if (stb.convIssue) sampleWord <= {{PAD_W{1'b0}}, adcData};
    end
  end

  // Flag set and clear; reset-hold dominates, set beats clear
  assign clrWrite = wrEn && (wrAddr == ADDR_W'(ADDR_FLAGS));

  always_comb begin
    setVec = '0;
    clrVec = clrWrite ? wrData[FLAG_N-1:0] : '0;
    setVec[FLAG_STOP]  = stb.stopDone && !stb.rstHold;
    setVec[FLAG_START] = stb.firstConv;
    setVec[FLAG_RSTID] = stb.rstHold;
    if (stb.rstHold) begin
      clrVec[FLAG_STOP]  = 1'b1;
      clrVec[FLAG_START] = 1'b1;
    end
  end

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         irqFlags[i] <= 1'b0;
      else if (setVec[i]) irqFlags[i] <= 1'b1;
      else if (clrVec[i]) irqFlags[i] <= 1'b0;
    end
  end

endmodule

// File: rtl/mic_seq_top.sv
module mic_seq_top
  import mic_seq_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int DATA_W     = 16,
  parameter int SMP_W      = 10,
  parameter int ADDR_W     = 3,
  parameter int PERIOD_RST = 32768,
  parameter int DELAY_RST  = 164
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SMP_W-1:0]  adcData,
  output logic              convReq,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleWord,
  output logic [FLAG_N-1:0] irqFlags
);

  seqStb_t ctlStb;

  mic_seq_ctrl #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .PERIOD_RST(PERIOD_RST), .DELAY_RST(DELAY_RST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .stb(ctlStb)
  );

  mic_seq_dp #(
    .DATA_W(DATA_W), .SMP_W(SMP_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .stb(ctlStb), .adcData(adcData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .sampleValid(sampleValid), .sampleWord(sampleWord), .irqFlags(irqFlags)
  );

  assign convReq = ctlStb.convIssue;

endmodule

// File: rtl/mic_seq_chk.sv
module mic_seq_chk
  import mic_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SMP_W  = 10
) (
  input logic              clk,
  input logic              rst_n,
  input seqStb_t           stb,
  input logic              convReq,
  input logic [SMP_W-1:0]  adcData,
  input logic              sampleValid,
  input logic [DATA_W-1:0] sampleWord,
  input logic [FLAG_N-1:0] irqFlags
);

  // R6: a request yields the latched sample one cycle later
  a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    convReq |=> sampleValid && sampleWord[SMP_W-1:0] == $past(adcData));

  // R6: no valid strobe without a request in the cycle before
  a_r6_valid_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> $past(convReq));

  // R6: upper bits of the word are zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> sampleWord[DATA_W-1:SMP_W] == '0);

  // R8: start flag is up with the first request
  a_r8_start_flag: assert property (@(posedge clk) disable iff (!rst_n)
    stb.firstConv |=> irqFlags[FLAG_START] && convReq);

  // R9: stop sets the flag and no sample trails it
  a_r9_stop_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.stopDone && !stb.rstHold) |=> irqFlags[FLAG_STOP] && !sampleValid);

  // R11: reset bit holds the unit idle with only the idle flag up
  a_r11_rst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stb.rstHold |=> !convReq && irqFlags[FLAG_RSTID]
                    && !irqFlags[FLAG_START] && !irqFlags[FLAG_STOP]);

endmodule

bind mic_seq_top mic_seq_chk #(.DATA_W(DATA_W), .SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stb(ctlStb), .convReq(convReq),
  .adcData(adcData), .sampleValid(sampleValid), .sampleWord(sampleWord),
  .irqFlags(irqFlags)
);

// File: tb/tb_mic_seq_top.sv
module tb_mic_seq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [9:0]  adcData = '0;
  logic        convReq, sampleValid;
  logic [15:0] sampleWord;
  logic [2:0]  irqFlags;

  always #2 clk = ~clk;

  mic_seq_top dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .adcData(adcData), .convReq(convReq), .sampleValid(sampleValid),
    .sampleWord(sampleWord), .irqFlags(irqFlags)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int bad = 0;
  int lastWr = 0;
  int validCount = 0;
  int seed = 0;
  logic [15:0] expQ[$];
  int reqTimes[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); #1;
    lastWr = cyc;
    wrEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Driver: new converter value each cycle; expected word queued on request
  task automatic drvSample();
    adcData = 10'((seed * 37 + 11) ^ (seed >> 3));
    seed++;
    if (convReq) begin
      expQ.push_back({6'b0, adcData});
      reqTimes.push_back(cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) drvSample();

  // Monitor: compare each delivered word against the queue (R6)
  always @(negedge clk) begin
    if (rst_n && sampleValid) begin
      validCount++;
      if (expQ.size() == 0) chk(1'b0, "R6 unexpected sample", sampleWord, 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(sampleWord == e, "R6 sample word", sampleWord, e);
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int w, n, v0;
    waitCyc(3);
    rst_n = 1'b1;
    waitCyc(1);
    // R1
    chk(convReq == 0, "R1 convReq", convReq, 0);
    chk(sampleValid == 0, "R1 sampleValid", sampleValid, 0);
    chk(irqFlags == 0, "R1 irqFlags", irqFlags, 0);

    // R2: converter enable alone
    wr(3'd2, 16'd5);
    wr(3'd3, 16'd3);
    wr(3'd1, 16'd1);
    waitCyc(20);
    chk(reqTimes.size() == 0, "R2 adc only", reqTimes.size(), 0);

    // R3, R4, R8
    wr(3'd0, 16'd2);
    w = lastWr;
    waitCyc(40);
    chk(reqTimes[0] - w == 5, "R3 first request delay", reqTimes[0] - w, 5);
    chk(irqFlags[1] == 1, "R8 start flag", irqFlags[1], 1);
    for (int i = 1; i < 5; i++)
      chk(reqTimes[i] - reqTimes[i-1] == 5, "R4 spacing", reqTimes[i] - reqTimes[i-1], 5);

    // R5: period change at next boundary
    n = reqTimes.size();
    wait (reqTimes.size() > n);
    wr(3'd2, 16'd8);
    waitCyc(30);
    chk(reqTimes[n+1] - reqTimes[n] == 5, "R5 old interval", reqTimes[n+1] - reqTimes[n], 5);
    chk(reqTimes[n+2] - reqTimes[n+1] == 8, "R5 new interval", reqTimes[n+2] - reqTimes[n+1], 8);
    chk(reqTimes[n+3] - reqTimes[n+2] == 8, "R5 new interval", reqTimes[n+3] - reqTimes[n+2], 8);

    // R10: write-one-to-clear
    wr(3'd4, 16'd0);
    waitCyc(1);
    chk(irqFlags[1] == 1, "R10 zero write keeps", irqFlags[1], 1);
    wr(3'd4, 16'd2);
    waitCyc(1);
    chk(irqFlags[1] == 0, "R10 one write clears", irqFlags[1], 0);

    // R9: stop while running
    wr(3'd1, 16'd0);
    waitCyc(2);
    n = reqTimes.size();
    v0 = validCount;
    waitCyc(20);
    chk(irqFlags[0] == 1, "R9 stop flag", irqFlags[0], 1);
    chk(validCount == v0, "R9 no trailing sample", validCount, v0);
    chk(reqTimes.size() == n, "R9 no request", reqTimes.size(), n);

    // R7: abort during settling, then full restart
    wr(3'd3, 16'd10);
    wr(3'd1, 16'd1);
    waitCyc(5);
    wr(3'd1, 16'd0);
    waitCyc(5);
    chk(reqTimes.size() == n, "R7 abort", reqTimes.size(), n);
    wr(3'd1, 16'd1);
    w = lastWr;
    waitCyc(20);
    chk(reqTimes.size() > n, "R7 restart issues", reqTimes.size(), n + 1);
    if (reqTimes.size() > n)
      chk(reqTimes[n] - w == 12, "R7 restart delay", reqTimes[n] - w, 12);

    // R11: unit reset bit
    wr(3'd0, 16'd1);
    waitCyc(2);
    chk(irqFlags == 3'b100, "R11 flags under reset", irqFlags, 4);
    n = reqTimes.size();
    waitCyc(10);
    chk(reqTimes.size() == n, "R11 held idle", reqTimes.size(), n);
    wr(3'd0, 16'd0);
    waitCyc(10);
    chk(reqTimes.size() == n, "R11 idle after release", reqTimes.size(), n);
    chk(irqFlags == 3'b100, "R11 idle flag sticky", irqFlags, 4);
    wr(3'd4, 16'd4);
    waitCyc(1);
    chk(irqFlags == 0, "R10 clear idle flag", irqFlags, 0);

    // R2: microphone enable alone
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd2);
    waitCyc(20);
    chk(reqTimes.size() == n, "R2 mic only", reqTimes.size(), n);

    waitCyc(2);
    chk(expQ.size() == 0, "R6 pending samples", expQ.size(), 0);
    summary();
  end

endmodule